// File: doc/BRIEF.md
# Replay FIFO with Half-Full Flag

A single-clock first-in first-out buffer of 9-bit words whose depth is a power-of-two parameter (256 by default; 512, 1024, 2048 and 4096 are also intended sizes). Words leave in the order they arrived. A producer pulses `wrEn` with a word on `wrData`. A consumer pulses `rdEn` and picks the word up on `rdData` one cycle later, qualified by `rdValid`. `rdValid` is low whenever no read took place, which stands in for a floating bus.

Three active-high status flags report occupancy. `empty` means nothing is stored. `halfFull` means more than half the capacity is in use. `full` means every location is taken. Writes to a full buffer and reads from an empty one are dropped.

A `rewind` pulse moves the read side back to physical location zero, so a receiver can replay a packet it did not accept. Rewind is only accepted while both strobes are idle. If it arrives together with a strobe, it is refused and reported on `protoErr`.

Top module: `replayFifo`

## Requirements
- R1: Words are 9 bits wide; depth is a power-of-two parameter `DEPTH`; words are returned in write order.
- R2: After `mrst` (synchronous, active high), `empty`=1 and `full`=0, `halfFull`=0, `rdValid`=0 and `protoErr`=0. A read issued right after reset gives `rdValid`=0.
- R3: A write while `full`=1 is dropped: `full` stays 1 and the dropped word is never read out.
- R4: A read while `empty`=1 is dropped: `rdValid` stays 0 and the read position does not move, so the next word written is the next word read.
- R5: `halfFull` rises on the write that makes occupancy DEPTH/2+1. It falls on the read that brings occupancy back to DEPTH/2.
- R6: `full` rises on the write that makes occupancy DEPTH and falls after any read from a full buffer. `empty` and `full` are never both 1.
- R7: An accepted `rewind` sets the read position to location 0. Occupancy becomes the number of words written since reset: the write position, or DEPTH when the write position has wrapped back to exactly 0. All three flags reflect that occupancy in the next cycle.
- R8: After a rewind, reads replay from location 0 up to the write position, and words written after the rewind follow in order.
- R9: A `rewind` while `wrEn` or `rdEn` is 1 is ignored; the strobes act normally and `protoErr` is 1 for the following cycle only.
- R10: A read and a write in the same cycle on a buffer that is neither empty nor full both take place, and occupancy is unchanged.
- R11: Flags, `rdData` and `rdValid` are registered. They reflect a strobe sampled at clock edge k right after edge k, and `rdValid` is 0 in any cycle not preceded by an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Synchronous master reset, active high |
| wrEn | input | 1 | Write strobe |
| wrData | input | 9 | Word to write |
| rdEn | input | 1 | Read strobe |
| rewind | input | 1 | Rewind read side to location 0 |
| rdData | output | 9 | Word read |
| rdValid | output | 1 | rdData holds a word read in the previous cycle |
| empty | output | 1 | Nothing stored |
| halfFull | output | 1 | Occupancy above DEPTH/2 |
| full | output | 1 | Occupancy equals DEPTH |
| protoErr | output | 1 | Rewind was refused in the previous cycle |

## Verification
Every result is due exactly one clock edge after the strobe that causes it. This holds for the flags, the read word and its qualifier, the rewound occupancy and the error pulse. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge, so each check reads the state left by exactly one edge. The half and full thresholds are checked on the exact write and read that cross them. Rewind is checked both with the write position wrapped to zero and with it part-way round.

// File: rtl/replayFifoPkg.sv
package replayFifoPkg;
  // Accepted operations for one cycle, issued by control to the datapath.
  typedef struct packed {
    logic push;
    logic pop;
    logic rewind;
  } fifoCmd_t;
endpackage

// File: rtl/replayFifoCtrl.sv
module replayFifoCtrl
  import replayFifoPkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                       clk,
  input  logic                       mrst,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic                       rewind,
  input  logic [$clog2(DEPTH):0]     wordsWritten,
  output fifoCmd_t                   cmd,
  output logic                       empty,
  output logic                       full,
  output logic                       halfFull,
  output logic                       protoErr
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  logic [CW-1:0] count;
  logic [CW-1:0] countNext;

  // Gate strobes with the registered flags; rewind only when both strobes idle.
  always_comb begin
    cmd.push   = wrEn && !full;
    cmd.pop    = rdEn && !empty;
    cmd.rewind = rewind && !wrEn && !rdEn;
    countNext  = count;
    if (cmd.rewind) begin
      countNext = wordsWritten;
    end else begin
      unique case ({cmd.push, cmd.pop})
        2'b10:   countNext = count + CW'(1);
        2'b01:   countNext = count - CW'(1);
        default: countNext = count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (mrst) begin
      count    <= '0;
      empty    <= 1'b1;
      full     <= 1'b0;
      halfFull <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      count    <= countNext;
      empty    <= (countNext == '0);
      full     <= (countNext == CW'(DEPTH));
      halfFull <= (countNext > CW'(HALF));
      protoErr <= rewind && (wrEn || rdEn);
    end
  end
endmodule

// File: rtl/replayFifoData.sv
module replayFifoData
  import replayFifoPkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 256
) (
  input  logic                   clk,
  input  logic                   mrst,
  input  fifoCmd_t               cmd,
  input  logic [WIDTH-1:0]       wrData,
  output logic [WIDTH-1:0]       rdData,
  output logic                   rdValid,
  output logic [$clog2(DEPTH):0] wordsWritten
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  generate
    if ((1 << AW) != DEPTH) begin : gBadDepth
      $error("DEPTH must be a power of two");
    end
  endgenerate

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;
  logic             wrapped;

  always_ff @(posedge clk) begin
    if (cmd.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (mrst) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      wrapped <= 1'b0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      if (cmd.push) begin
        wrPtr <= wrPtr + AW'(1);
        if (wrPtr == AW'(DEPTH - 1)) wrapped <= 1'b1;
      end
      if (cmd.rewind)   rdPtr <= '0;
      else if (cmd.pop) rdPtr <= rdPtr + AW'(1);
      rdValid <= cmd.pop;
      if (cmd.pop) rdData <= mem[rdPtr];
    end
  end

  // Words written since reset; a pointer back at zero after a wrap means DEPTH.
  assign wordsWritten = (wrapped && (wrPtr == '0)) ? CW'(DEPTH) : {1'b0, wrPtr};
endmodule

// File: rtl/replayFifo.sv
module replayFifo
  import replayFifoPkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  input  logic             rewind,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid,
  output logic             empty,
  output logic             halfFull,
  output logic             full,
  output logic             protoErr
);
  localparam int CW = $clog2(DEPTH) + 1;

  fifoCmd_t      cmd;
  logic [CW-1:0] wordsWritten;

  replayFifoCtrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .mrst(mrst), .wrEn(wrEn), .rdEn(rdEn), .rewind(rewind),
    .wordsWritten(wordsWritten), .cmd(cmd), .empty(empty), .full(full),
    .halfFull(halfFull), .protoErr(protoErr)
  );

  replayFifoData #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uData (
    .clk(clk), .mrst(mrst), .cmd(cmd), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .wordsWritten(wordsWritten)
  );
endmodule

// File: rtl/replayFifoChk.sv
module replayFifoChk (
  input logic clk,
  input logic mrst,
  input logic wrEn,
  input logic rdEn,
  input logic rewind,
  input logic rdValid,
  input logic empty,
  input logic halfFull,
  input logic full,
  input logic protoErr
);
  logic rstSeen = 1'b0;

  // R2: the cycle after reset shows the cleared state
  always @(posedge clk) begin
    if (rstSeen) begin
      a_r2_reset_state: assert (empty && !full && !halfFull && !rdValid && !protoErr)
        else $error("reset state wrong");
    end
    rstSeen <= mrst;
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (mrst)
    full && wrEn && !rdEn |=> full);

  a_r4_no_underflow: assert property (@(posedge clk) disable iff (mrst)
    empty && rdEn && !wrEn |=> empty && !rdValid);

  a_r6_full_release: assert property (@(posedge clk) disable iff (mrst)
    full && rdEn |=> !full);

  a_r6_not_both: assert property (@(posedge clk) disable iff (mrst)
    !(empty && full));

  a_r9_proto_err: assert property (@(posedge clk) disable iff (mrst)
    rewind && (wrEn || rdEn) |=> protoErr);

  a_r11_no_stray_valid: assert property (@(posedge clk) disable iff (mrst)
    !rdEn |=> !rdValid);
endmodule

bind replayFifo replayFifoChk uChk (
  .clk(clk), .mrst(mrst), .wrEn(wrEn), .rdEn(rdEn), .rewind(rewind),
  .rdValid(rdValid), .empty(empty), .halfFull(halfFull), .full(full),
  .protoErr(protoErr)
);

// File: tb/sim_replayFifo.sv
module sim_replayFifo;
  localparam int W = 9;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic mrst = 1'b1, wrEn = 1'b0, rdEn = 1'b0, rewind = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic rdValid, empty, halfFull, full, protoErr;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  replayFifo #(.WIDTH(W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .mrst(mrst), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rewind(rewind), .rdData(rdData), .rdValid(rdValid), .empty(empty),
    .halfFull(halfFull), .full(full), .protoErr(protoErr)
  );

  // Vector: [24]wr [23]rd [22]rewind [21:13]data | [12]valid [11:3]rdData [2]empty [1]half [0]full
  localparam int NV = 8;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 9'h000, 1'b0, 9'h000, 1'b1, 1'b0, 1'b0}, // R4 read on empty
    {1'b1, 1'b0, 1'b0, 9'h101, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 9'h0A2, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b0, 9'h000, 1'b1, 9'h101, 1'b0, 1'b0, 1'b0}, // R1 order
    {1'b1, 1'b1, 1'b0, 9'h033, 1'b1, 9'h0A2, 1'b0, 1'b0, 1'b0}, // R10 both
    {1'b0, 1'b0, 1'b0, 9'h000, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0}, // R11 idle
    {1'b0, 1'b1, 1'b0, 9'h000, 1'b1, 9'h033, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b0, 9'h000, 1'b0, 9'h000, 1'b1, 1'b0, 1'b0}  // R4
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic t, input logic [W-1:0] d);
    wrEn = w; rdEn = r; rewind = t; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; rewind = 1'b0;
  endtask

  task automatic doReset();
    mrst = 1'b1;
    repeat (2) @(negedge clk);
    mrst = 1'b0;
  endtask

  task automatic flags(input string tag, input logic e, input logic h, input logic f);
    chk({tag, " empty"}, 16'(empty), 16'(e));
    chk({tag, " halfFull"}, 16'(halfFull), 16'(h));
    chk({tag, " full"}, 16'(full), 16'(f));
  endtask

  task automatic readExp(input string tag, input logic [W-1:0] d);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk({tag, " valid"}, 16'(rdValid), 16'd1);
    chk({tag, " data"}, 16'(rdData), 16'(d));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    flags("R2 reset", 1'b1, 1'b0, 1'b0);
    chk("R2 valid", 16'(rdValid), 16'd0);
    chk("R2 protoErr", 16'(protoErr), 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      cyc(v[24], v[23], v[22], v[21:13]);
      chk("R1 R11 vector valid", 16'(rdValid), 16'(v[12]));
      if (v[12]) chk("R1 R10 vector data", 16'(rdData), 16'(v[11:3]));
      flags("R4 R10 vector", v[2], v[1], v[0]);
    end

    // Fill through the thresholds
    doReset();
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R2 read after reset valid", 16'(rdValid), 16'd0);
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1'b1, 1'b0, 1'b0, W'(9'h10 + i));
      if (i == DEPTH / 2 - 1) flags("R5 at half", 1'b0, 1'b0, 1'b0);
      if (i == DEPTH / 2)     flags("R5 at half+1", 1'b0, 1'b1, 1'b0);
      if (i == DEPTH - 2)     flags("R6 one short", 1'b0, 1'b1, 1'b0);
    end
    flags("R6 filled", 1'b0, 1'b1, 1'b1);
    cyc(1'b1, 1'b0, 1'b0, 9'h1FF);
    flags("R3 write on full", 1'b0, 1'b1, 1'b1);
    readExp("R6 read from full", 9'h10);
    chk("R6 full released", 16'(full), 16'd0);
    readExp("R1 drain", 9'h11);
    readExp("R1 drain", 9'h12);
    flags("R5 occupancy half+1", 1'b0, 1'b1, 1'b0);
    readExp("R5 drain", 9'h13);
    flags("R5 occupancy half", 1'b0, 1'b0, 1'b0);
    for (int i = 4; i < DEPTH; i++) readExp("R3 drain no dropped word", W'(9'h10 + i));
    chk("R3 empty after drain", 16'(empty), 16'd1);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R3 dropped word absent", 16'(rdValid), 16'd0);

    // Rewind with write position wrapped to zero
    cyc(1'b0, 1'b0, 1'b1, '0);
    flags("R7 wrapped rewind", 1'b0, 1'b1, 1'b1);
    chk("R7 protoErr quiet", 16'(protoErr), 16'd0);
    for (int i = 0; i < DEPTH; i++) readExp("R8 replay", W'(9'h10 + i));
    flags("R8 replay done", 1'b1, 1'b0, 1'b0);

    // Partial rewind
    doReset();
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, W'(9'h0A0 + i));
    readExp("R1 partial", 9'h0A0);
    readExp("R1 partial", 9'h0A1);
    cyc(1'b0, 1'b0, 1'b1, '0);
    flags("R7 partial rewind", 1'b0, 1'b0, 1'b0);
    readExp("R8 replay first", 9'h0A0);
    cyc(1'b1, 1'b0, 1'b0, 9'h0B0);
    readExp("R8 replay", 9'h0A1);
    readExp("R8 replay", 9'h0A2);
    readExp("R8 word after rewind", 9'h0B0);
    chk("R8 empty at write position", 16'(empty), 16'd1);

    // Refused rewind
    cyc(1'b1, 1'b0, 1'b1, 9'h0C0);
    chk("R9 protoErr set", 16'(protoErr), 16'd1);
    chk("R9 write still done", 16'(empty), 16'd0);
    cyc(1'b0, 1'b0, 1'b0, '0);
    chk("R9 protoErr one cycle", 16'(protoErr), 16'd0);
    readExp("R9 read position kept", 9'h0C0);
    chk("R9 empty again", 16'(empty), 16'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule